// File: doc/BRIEF.md
# Prioritized Interrupt Request Arbiter

This block gathers every interrupt request that reaches the CPU and presents it as one request. The inputs are one non-maskable line, a set of external pin requests and a set of on-chip peripheral requests. Each of the pin and peripheral requests is a maskable source with its own 4-bit programmable priority. Each cycle the arbiter finds the highest-priority pending maskable source. It compares that priority with the CPU's current 4-bit mask level and its block bit. It then registers a single request carrying a 5-bit level and a source code.

The non-maskable line is edge-sensitive, and a control input selects the rising or the falling edge. The line is synchronised and the chosen edge is latched as a pending flag. The flag always wins at the reserved top level 16, but it is offered only while the block bit is clear or the CPU reports a sleep or standby state. This lets it wake the device. The CPU side clears the flag with an acknowledge pulse.

Maskable requests are level-sensitive and are taken from the inputs as they stand. The arbiter never changes the CPU's mask level, and it has no output that could change it. Vector fetch and context saving belong to the CPU.

Top module: `irq_arbiter`

## Requirements
- R1: While reset is asserted and after its release, with no request pending, `irq_valid` is 0.
- R2: A maskable source whose 4-bit priority is 0 is never presented, whatever its request line does.
- R3: A maskable winner of priority P is presented, one clock after the inputs settle, only when P is strictly greater than `cpu_mask` and `cpu_block` is 0. It is presented with `irq_level` = P, zero-extended to 5 bits.
- R4: The maskable winner is the pending source with the highest priority. Equal priorities go to the lowest source index. Pin i is index i and peripheral j is index N_PIN+j. Its priority sits in `prio_cfg[4*index +: 4]`, and `irq_src` = index+1.
- R5: With `nmi_rise_sel`=1 a low-to-high transition of `nmi_pin` makes the non-maskable request pending. With `nmi_rise_sel`=0 a high-to-low transition does so. The opposite edge has no effect.
- R6: A presented non-maskable request shows `irq_level`=16 and `irq_src`=0, and it pre-empts every maskable source regardless of `cpu_mask`.
- R7: A pending non-maskable request is presented only while `cpu_block` is 0 or `low_power` is 1. While it is blocked it stays pending.
- R8: A one-cycle `nmi_ack` pulse clears the pending non-maskable request unless a new selected edge arrives in the same cycle.
- R9: `low_power` does not lift `cpu_block` for maskable sources.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_pin | input | 1 | Non-maskable request line (asynchronous) |
| nmi_rise_sel | input | 1 | 1: rising edge active, 0: falling edge active |
| nmi_ack | input | 1 | Clears the pending non-maskable request |
| pin_req | input | N_PIN | External pin requests, level-sensitive |
| peri_req | input | N_PERI | On-chip peripheral requests, level-sensitive |
| prio_cfg | input | 4*(N_PIN+N_PERI) | Priority of each maskable source, 4 bits each |
| cpu_mask | input | 4 | CPU current mask level |
| cpu_block | input | 1 | CPU block bit |
| low_power | input | 1 | CPU is in sleep or standby |
| irq_valid | output | 1 | Interrupt request to the CPU |
| irq_level | output | 5 | Level of the presented request (16 = non-maskable) |
| irq_src | output | $clog2(N_PIN+N_PERI+1) | Source code: 0 non-maskable, index+1 otherwise |

## Verification
The bench builds the arbiter with N_PIN=3 and N_PERI=4, which gives seven maskable sources and a 3-bit source code. With these values the bench can reach the all-ones source code and ties that span pins and peripherals. It also reaches a winner at the last peripheral index. A bench-side priority search checks a set of arithmetic request and priority patterns against the registered output. Directed scenarios cover both edge polarities, a non-maskable request held while blocked and released later, the wake-up path through the low-power input, and clearing by acknowledge.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int unsigned PRIO_W    = 4;
  localparam int unsigned OUT_LVL_W = PRIO_W + 1;
  localparam logic [OUT_LVL_W-1:0] NMI_LEVEL = 5'd16;

  typedef struct packed {
    logic                 valid;
    logic [OUT_LVL_W-1:0] level;
  } irq_req_t;
endpackage

// File: rtl/arb_rst_sync.sv
module arb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_sync_n = out_q;
endmodule

// File: rtl/nmi_edge_det.sv
module nmi_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_pin,
  input  logic rise_sel,
  input  logic ack,
  output logic pend
);
  logic sync1_q, sync2_q, prev_q, pend_q;
  logic edge_hit, pend_d;

  // two-stage synchroniser, then a history flop for edge detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      prev_q  <= 1'b0;
    end else begin
      sync1_q <= nmi_pin;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  always_comb begin
    edge_hit = rise_sel ? (sync2_q & ~prev_q) : (~sync2_q & prev_q);
    if (edge_hit)  pend_d = 1'b1;
    else if (ack)  pend_d = 1'b0;
    else           pend_d = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign pend = pend_q;

  // R5
  edge_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_hit |=> pend);

  // R8
  ack_clears_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !edge_hit) |=> !pend);
endmodule

// File: rtl/prio_select.sv
module prio_select #(
  parameter int unsigned N_SRC  = 8,
  parameter int unsigned LVL_W  = 4,
  parameter int unsigned IDX_W  = 3
) (
  input  logic [N_SRC-1:0]       req,
  input  logic [N_SRC*LVL_W-1:0] lvl_flat,
  output logic                   found,
  output logic [LVL_W-1:0]       win_lvl,
  output logic [IDX_W-1:0]       win_idx
);
  logic [LVL_W-1:0] lvl [N_SRC];

  for (genvar gi = 0; gi < N_SRC; gi++) begin : g_unpack
    assign lvl[gi] = lvl_flat[gi*LVL_W +: LVL_W];
  end

  // strict compare keeps the lowest index on ties; level 0 never beats the seed
  always_comb begin
    win_lvl = '0;
    win_idx = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (req[i] && (lvl[i] > win_lvl)) begin
        win_lvl = lvl[i];
        win_idx = IDX_W'(i);
      end
    end
    found = (win_lvl != '0);
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_arb_pkg::*;
#(
  parameter int unsigned N_PIN  = 6,
  parameter int unsigned N_PERI = 10,
  localparam int unsigned N_SRC = N_PIN + N_PERI,
  localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1,
  localparam int unsigned SRC_W = $clog2(N_SRC + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    nmi_pin,
  input  logic                    nmi_rise_sel,
  input  logic                    nmi_ack,
  input  logic [N_PIN-1:0]        pin_req,
  input  logic [N_PERI-1:0]       peri_req,
  input  logic [N_SRC*PRIO_W-1:0] prio_cfg,
  input  logic [PRIO_W-1:0]       cpu_mask,
  input  logic                    cpu_block,
  input  logic                    low_power,
  output logic                    irq_valid,
  output logic [OUT_LVL_W-1:0]    irq_level,
  output logic [SRC_W-1:0]        irq_src
);
  logic rst_sync_n;
  logic nmi_pend;
  logic win_found;
  logic [PRIO_W-1:0] win_lvl;
  logic [IDX_W-1:0]  win_idx;
  logic nmi_take, mask_take;
  irq_req_t req_d, req_q;
  logic [SRC_W-1:0] src_d, src_q;

  arb_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  nmi_edge_det u_nmi (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .nmi_pin  (nmi_pin),
    .rise_sel (nmi_rise_sel),
    .ack      (nmi_ack),
    .pend     (nmi_pend)
  );

  prio_select #(
    .N_SRC (N_SRC),
    .LVL_W (PRIO_W),
    .IDX_W (IDX_W)
  ) u_sel (
    .req      ({peri_req, pin_req}),
    .lvl_flat (prio_cfg),
    .found    (win_found),
    .win_lvl  (win_lvl),
    .win_idx  (win_idx)
  );

  // next-state: non-maskable first, then the maskable winner against the mask
  always_comb begin
    nmi_take  = nmi_pend & (~cpu_block | low_power);
    mask_take = win_found & ~cpu_block & (win_lvl > cpu_mask);
    req_d     = '0;
    src_d     = '0;
    if (nmi_take) begin
      req_d.valid = 1'b1;
      req_d.level = NMI_LEVEL;
    end else if (mask_take) begin
      req_d.valid = 1'b1;
      req_d.level = {1'b0, win_lvl};
      src_d       = SRC_W'(win_idx) + SRC_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      req_q <= '0;
      src_q <= '0;
    end else begin
      req_q <= req_d;
      src_q <= src_d;
    end
  end

  assign irq_valid = req_q.valid;
  assign irq_level = req_q.level;
  assign irq_src   = src_q;

  // R2
  level_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_valid |-> (irq_level != '0));

  // R6
  nmi_level_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (irq_valid && irq_src == '0) |-> (irq_level == NMI_LEVEL));

  // R3
  mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (irq_valid && irq_src != '0) |->
      (irq_level[OUT_LVL_W-1] == 1'b0 && !$past(cpu_block) &&
       irq_level[PRIO_W-1:0] > $past(cpu_mask)));

  // R7
  nmi_gate_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (irq_valid && irq_src == '0) |-> (!$past(cpu_block) || $past(low_power)));

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_sync_n |=> !irq_valid);
endmodule

// File: tb/tb_irq_arbiter.sv
module tb_irq_arbiter;
  localparam int N_PIN  = 3;
  localparam int N_PERI = 4;
  localparam int N_SRC  = N_PIN + N_PERI;
  localparam int SRC_W  = $clog2(N_SRC + 1);

  logic clk = 1'b0;
  logic rst_n;
  logic nmi_pin, nmi_rise_sel, nmi_ack;
  logic [N_PIN-1:0]  pin_req;
  logic [N_PERI-1:0] peri_req;
  logic [3:0] prio [N_SRC];
  logic [N_SRC*4-1:0] prio_cfg;
  logic [3:0] cpu_mask;
  logic cpu_block, low_power;
  logic irq_valid;
  logic [4:0] irq_level;
  logic [SRC_W-1:0] irq_src;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  always_comb
    for (int i = 0; i < N_SRC; i++) prio_cfg[4*i +: 4] = prio[i];

  irq_arbiter #(.N_PIN(N_PIN), .N_PERI(N_PERI)) dut (
    .clk(clk), .rst_n(rst_n), .nmi_pin(nmi_pin), .nmi_rise_sel(nmi_rise_sel),
    .nmi_ack(nmi_ack), .pin_req(pin_req), .peri_req(peri_req),
    .prio_cfg(prio_cfg), .cpu_mask(cpu_mask), .cpu_block(cpu_block),
    .low_power(low_power), .irq_valid(irq_valid), .irq_level(irq_level),
    .irq_src(irq_src)
  );

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic ev, input logic [4:0] el,
                       input logic [SRC_W-1:0] es);
    checks++;
    if (irq_valid !== ev || (ev && (irq_level !== el || irq_src !== es))) begin
      errors++;
      $display("FAIL %s: got valid=%0b level=%0d src=%0d, expected valid=%0b level=%0d src=%0d",
               tag, irq_valid, irq_level, irq_src, ev, el, es);
    end
  endtask

  // reference priority search over maskable sources
  task automatic ref_check(input string tag);
    logic [N_SRC-1:0] r;
    int best_l, best_i;
    r = {peri_req, pin_req};
    best_l = 0; best_i = 0;
    for (int i = 0; i < N_SRC; i++)
      if (r[i] && int'(prio[i]) > best_l) begin best_l = int'(prio[i]); best_i = i; end
    if (best_l != 0 && !cpu_block && best_l > int'(cpu_mask))
      check(tag, 1'b1, 5'(best_l), SRC_W'(best_i + 1));
    else
      check(tag, 1'b0, 5'd0, '0);
  endtask

  task automatic clear_all();
    pin_req = '0; peri_req = '0; cpu_mask = 4'd0; cpu_block = 1'b0; low_power = 1'b0;
    for (int i = 0; i < N_SRC; i++) prio[i] = 4'd0;
  endtask

  task automatic pulse_ack();
    nmi_ack = 1'b1; wait_n(1); nmi_ack = 1'b0; wait_n(3);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; nmi_pin = 1'b0; nmi_rise_sel = 1'b1; nmi_ack = 1'b0;
    clear_all();
    wait_n(3);
    check("R1 in reset", 1'b0, 5'd0, '0);
    rst_n = 1'b1; wait_n(4);
    check("R1 after release", 1'b0, 5'd0, '0);
  endtask

  task automatic t_level_zero();
    clear_all();
    pin_req = '1; peri_req = '1; wait_n(3);
    check("R2 all priorities zero", 1'b0, 5'd0, '0);
    prio[2] = 4'd5; wait_n(3);
    check("R2 only nonzero source wins", 1'b1, 5'd5, 3'd3);
  endtask

  task automatic t_mask();
    clear_all();
    peri_req[1] = 1'b1; prio[4] = 4'd7; cpu_mask = 4'd7; wait_n(3);
    check("R3 level equal to mask held off", 1'b0, 5'd0, '0);
    cpu_mask = 4'd6; wait_n(3);
    check("R3 level above mask presented", 1'b1, 5'd7, 3'd5);
    cpu_block = 1'b1; wait_n(3);
    check("R3 block bit stops maskable", 1'b0, 5'd0, '0);
    low_power = 1'b1; wait_n(3);
    check("R9 low power does not lift block", 1'b0, 5'd0, '0);
    cpu_block = 1'b0; wait_n(3);
    check("R9 low power alone passes maskable", 1'b1, 5'd7, 3'd5);
  endtask

  task automatic t_priority();
    clear_all();
    for (int k = 0; k < 24; k++) begin
      for (int i = 0; i < N_SRC; i++) prio[i] = 4'((k * 5 + i * 7 + (k ^ i)) % 16);
      pin_req  = N_PIN'(k * 3 + 1);
      peri_req = N_PERI'(k * 11 + 5);
      cpu_mask = 4'((k * 3) % 9);
      cpu_block = (k % 7 == 6);
      wait_n(3);
      ref_check($sformatf("R4 pattern %0d", k));
    end
  endtask

  task automatic t_tie();
    clear_all();
    pin_req[1] = 1'b1; peri_req[2] = 1'b1; prio[1] = 4'd9; prio[5] = 4'd9; wait_n(3);
    check("R4 tie goes to lowest index", 1'b1, 5'd9, 3'd2);
    prio[5] = 4'd10; wait_n(3);
    check("R4 higher peripheral beats pin", 1'b1, 5'd10, 3'd6);
    clear_all();
    peri_req[3] = 1'b1; prio[6] = 4'd15; cpu_mask = 4'd14; wait_n(3);
    check("R4 last peripheral code", 1'b1, 5'd15, 3'd7);
  endtask

  task automatic t_nmi_edges();
    clear_all();
    pin_req[0] = 1'b1; prio[0] = 4'd15;
    nmi_rise_sel = 1'b1; nmi_pin = 1'b0; wait_n(3);
    nmi_pin = 1'b1; wait_n(3); nmi_pin = 1'b0; wait_n(3);
    check("R6 rising edge NMI pre-empts level 15", 1'b1, 5'd16, 3'd0);
    cpu_mask = 4'd15; wait_n(2);
    check("R6 NMI ignores mask", 1'b1, 5'd16, 3'd0);
    cpu_mask = 4'd0;
    pulse_ack();
    check("R8 ack clears NMI", 1'b1, 5'd15, 3'd1);
    nmi_rise_sel = 1'b0; nmi_pin = 1'b1; wait_n(5);
    check("R5 rising edge ignored in falling mode", 1'b1, 5'd15, 3'd1);
    nmi_pin = 1'b0; wait_n(5);
    check("R5 falling edge taken", 1'b1, 5'd16, 3'd0);
    pulse_ack();
    nmi_rise_sel = 1'b1;
    pin_req = '0; wait_n(3);
    check("R8 idle after ack", 1'b0, 5'd0, '0);
  endtask

  task automatic t_nmi_gate();
    clear_all();
    cpu_block = 1'b1;
    nmi_pin = 1'b1; wait_n(3); nmi_pin = 1'b0; wait_n(4);
    check("R7 NMI held off by block", 1'b0, 5'd0, '0);
    cpu_block = 1'b0; wait_n(2);
    check("R7 NMI kept pending then presented", 1'b1, 5'd16, 3'd0);
    pulse_ack();
    cpu_block = 1'b1; low_power = 1'b1;
    nmi_pin = 1'b1; wait_n(3); nmi_pin = 1'b0; wait_n(4);
    check("R7 NMI wakes through low power", 1'b1, 5'd16, 3'd0);
    pulse_ack();
    check("R8 cleared in low power", 1'b0, 5'd0, '0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_level_zero();
    t_mask();
    t_priority();
    t_tie();
    t_nmi_edges();
    t_nmi_gate();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule